// File: doc/BRIEF.md
# Status Pin Replacement Register

This block is the card-side register that stands in for four status pins when the card's interface is running in I/O mode and those pins are no longer free to carry status. Four raw status inputs (write protect, ready, and two battery-voltage levels) are brought into the card clock domain by a synchroniser. Their present levels are returned in the low nibble of an 8-bit register. Any transition on an input, rising or falling, sets a sticky flag in the high nibble.

The host clears or sets the sticky flags through a masked write. Each low data bit selects whether the matching high flag is written, and the high data bit gives the value written. The OR of the flags forms a combined change indication. When the change-signal enable input is high, that indication drives an active-low status-change output to the host.

Top module: `pinrep_status`

## Requirements
- R1: Read bits 0..3 return the synchronised level of write protect (bit 0), ready (bit 1), battery-voltage-2 (bit 2) and battery-voltage-1 (bit 3). A change on a raw input shows in the read value after the second rising clock edge.
- R2: A transition in either direction on synchronised input i sets read bit 4+i on the third rising edge after the raw input changed.
- R3: A set change flag stays set through later input transitions until a write clears it.
- R4: On a write, flag i takes data bit 4+i only when data bit i is 1. Flags whose data bit i is 0 keep their value. Bits 0..3 are never written.
- R5: The combined change output is 1 exactly when at least one change flag is set.
- R6: The active-low status-change output is 0 exactly when the combined change output and the enable input are both 1.
- R7: When a detected transition and a write that clears the same flag occur on the same clock edge, the flag ends set.
- R8: During reset the read value is 0x00, the combined change output is 0 and the status-change output is 1.
- R9: Input differences seen while the synchroniser fills, during the first three rising edges after reset release, set no change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_stat_i | input | 4 | Unsynchronised status inputs: write protect, ready, battery-voltage-2, battery-voltage-1 |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_data_i | input | 8 | Write data: bits 0..3 mask, bits 4..7 flag values |
| sig_en_i | input | 1 | Enables the status-change output |
| rd_data_o | output | 8 | Register read value: flags in bits 7..4, levels in bits 3..0 |
| changed_o | output | 1 | OR of the four change flags |
| stschg_n_o | output | 1 | Active-low status-change request |

## Verification
The bench drives all 256 write bytes over preset flag patterns. A design that ignored the mask, or that let a masked-out bit clear its flag, would read back the wrong high nibble. It also walks the inputs through all sixteen patterns and returns them to earlier values, which catches flags that follow the level instead of holding, and flags that miss falling transitions. A clearing write is placed on the exact edge where a transition is latched; a design that gave priority to the write would lose that event. Inputs are held high across reset to expose flags set falsely by the synchroniser fill.

// File: rtl/pinrep_pkg.sv
package pinrep_pkg;

  localparam int unsigned STAT_LINES = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  // Next value of one sticky change flag: a detected transition always wins,
  // otherwise a masked write loads the supplied value, otherwise hold.
  function automatic logic sticky_next(input logic cur, input logic evt,
                                       input logic hit, input logic val);
    logic nxt;
    if (evt)      nxt = 1'b1;
    else if (hit) nxt = val;
    else          nxt = cur;
    return nxt;
  endfunction

  // Active-low request to the host.
  function automatic logic request_n(input logic any_chg, input logic en);
    return ~(any_chg & en);
  endfunction

endpackage

// File: rtl/pinrep_sync.sv
module pinrep_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pinrep_chgdet.sv
module pinrep_chgdet #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned FILL  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] evt_o
);

  localparam int unsigned CW = $clog2(FILL + 1);

  logic [WIDTH-1:0] prev_q;
  logic [CW-1:0]    fill_q;
  logic             primed;

  assign primed = (fill_q == CW'(FILL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= cur_i;
      if (!primed) fill_q <= fill_q + CW'(1);
    end
  end

  assign evt_o = primed ? (cur_i ^ prev_q) : '0;

endmodule

// File: rtl/pinrep_sticky.sv
module pinrep_sticky #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] flag_o
);

  import pinrep_pkg::*;

  logic [WIDTH-1:0] flag_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
      logic hit;
      assign hit = wr_en_i & mask_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= sticky_next(flag_q[i], evt_i[i], hit, val_i[i]);
      end
    end
  endgenerate

  assign flag_o = flag_q;

endmodule

// File: rtl/pinrep_status.sv
module pinrep_status #(
  parameter int unsigned LINES = pinrep_pkg::STAT_LINES,
  parameter int unsigned SYNC  = pinrep_pkg::SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   raw_stat_i,
  input  logic               wr_en_i,
  input  logic [2*LINES-1:0] wr_data_i,
  input  logic               sig_en_i,
  output logic [2*LINES-1:0] rd_data_o,
  output logic               changed_o,
  output logic               stschg_n_o
);

  import pinrep_pkg::*;

  localparam int unsigned FILL = SYNC + 1;

  logic [LINES-1:0] level_w;
  logic [LINES-1:0] evt_w;
  logic [LINES-1:0] flag_w;

  pinrep_sync #(.WIDTH(LINES), .STAGES(SYNC)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_stat_i),
    .q_o   (level_w)
  );

  pinrep_chgdet #(.WIDTH(LINES), .FILL(FILL)) det_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (level_w),
    .evt_o (evt_w)
  );

  pinrep_sticky #(.WIDTH(LINES)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_w),
    .wr_en_i (wr_en_i),
    .mask_i  (wr_data_i[LINES-1:0]),
    .val_i   (wr_data_i[2*LINES-1:LINES]),
    .flag_o  (flag_w)
  );

  assign rd_data_o  = {flag_w, level_w};
  assign changed_o  = |flag_w;
  assign stschg_n_o = request_n(changed_o, sig_en_i);

endmodule

// File: rtl/pinrep_status_chk.sv
module pinrep_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       sig_en_i,
  input logic [7:0] rd_data_o,
  input logic       changed_o,
  input logic       stschg_n_o,
  input logic [3:0] evt_i
);

  a_r6_request: assert property (@(posedge clk) disable iff (!rst_n)
    stschg_n_o == !(changed_o && sig_en_i));

  a_r5_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    changed_o == (rd_data_o[7:4] != 4'h0));

  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != 4'h0) |=> ((rd_data_o[7:4] & $past(evt_i)) == $past(evt_i)));

  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ((rd_data_o[7:4] & $past(rd_data_o[7:4])) == $past(rd_data_o[7:4])));

  a_r4_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (((rd_data_o[7:4] ^ $past(rd_data_o[7:4]))
                  & ~$past(wr_data_i[3:0]) & ~$past(evt_i)) == 4'h0));

  a_r4_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((rd_data_o[7:4] & $past(wr_data_i[3:0]))
                 == (($past(wr_data_i[7:4]) | $past(evt_i)) & $past(wr_data_i[3:0]))));

  always_comb begin
    if (!rst_n) begin
      a_r8_reset_idle: assert (rd_data_o[7:4] == 4'h0 && stschg_n_o);
    end
  end

endmodule

bind pinrep_status pinrep_status_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .sig_en_i   (sig_en_i),
  .rd_data_o  (rd_data_o),
  .changed_o  (changed_o),
  .stschg_n_o (stschg_n_o),
  .evt_i      (evt_w)
);

// File: tb/pinrep_status_tb.sv
module pinrep_status_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] raw = 4'h0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sig_en = 1'b0;
  logic [7:0] rd_data;
  logic       changed;
  logic       stschg_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_level = 4'h0;
  logic [3:0] m_flag  = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinrep_status dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_stat_i (raw),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .sig_en_i   (sig_en),
    .rd_data_o  (rd_data),
    .changed_o  (changed),
    .stschg_n_o (stschg_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    for (int i = 0; i < 4; i++)
      if (d[i]) m_flag[i] = d[4+i];
  endtask

  task automatic check_outputs(input string req);
    chk(req, rd_data, {m_flag, m_level});
    chk({req, " R5"}, {7'h0, changed}, {7'h0, |m_flag});
    chk({req, " R6"}, {7'h0, stschg_n}, {7'h0, !((|m_flag) && sig_en)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R8: reset state with inputs held high
    raw = 4'hF;
    nedge(3);
    chk("R8 read in reset", rd_data, 8'h00);
    chk("R8 changed in reset", {7'h0, changed}, 8'h00);
    chk("R8 request in reset", {7'h0, stschg_n}, 8'h01);
    rst_n = 1'b1;
    nedge(6);
    m_level = 4'hF;
    // R9: fill after reset sets no flag; R1 level visible
    chk("R9 R1 after fill", rd_data, 8'h0F);

    // R1/R2/R3: walk the inputs through all patterns
    sig_en = 1'b1;
    for (int step = 0; step < 40; step++) begin
      logic [3:0] nv;
      nv = 4'((step * 11 + 3) % 16);
      raw = nv;
      nedge(1);
      chk("R1 level not yet after one edge", {4'h0, rd_data[3:0]}, {4'h0, m_level});
      nedge(1);
      chk("R1 level after two edges", {4'h0, rd_data[3:0]}, {4'h0, nv});
      chk("R2 flag not yet after two edges", {4'h0, rd_data[7:4]}, {4'h0, m_flag});
      nedge(1);
      m_flag  = m_flag | (m_level ^ nv);
      m_level = nv;
      check_outputs("R2 R3 flags after transition");
      if (step % 5 == 4) begin
        sig_en = ~sig_en;
        nedge(1);
        check_outputs("R6 enable toggle");
        host_write(8'h0F);
        check_outputs("R4 clear all");
      end
    end

    // R4: exhaustive write bytes over preset flag patterns
    for (int w = 0; w < 256; w++) begin
      logic [3:0] p;
      p = 4'((w * 7 + 5) % 16);
      host_write({p, 4'hF});
      host_write(8'(w));
      chk("R4 masked write", rd_data, {m_flag, m_level});
      sig_en = w[0];
      nedge(1);
      chk("R6 request", {7'h0, stschg_n}, {7'h0, !((|m_flag) && sig_en)});
      chk("R5 combined", {7'h0, changed}, {7'h0, |m_flag});
    end

    // R7: transition and clearing write on the same edge, each line
    sig_en = 1'b1;
    for (int b = 0; b < 4; b++) begin
      host_write(8'h0F);
      raw = m_level ^ (4'h1 << b);
      nedge(2);
      wr_data = 8'h0F;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
      m_level = raw;
      m_flag  = 4'h1 << b;
      check_outputs("R7 event beats clear");
      host_write(8'h0F);
      check_outputs("R7 later clear");
    end

    finish_run();
  end

endmodule